// File: doc/BRIEF.md
# Packed Horizontal Subtract Unit

This block is a SIMD datapath stage for a vector execution pipeline. It takes two packed operand vectors. Inside each vector, it pairs up neighbouring signed elements and computes the lower-addressed element minus the higher-addressed element. All of these differences are packed into one result vector. The element size is either 16 bits or 32 bits, and each difference is as wide as the elements it came from.

The datapath is split into 128-bit lanes, and no pair ever crosses a lane boundary. The form select decides what happens to the destination bits above the first lane:
- The legacy narrow form passes through the old destination value, which arrives on the first-source port.
- The zeroing narrow form clears those bits.
- The wide form computes every lane.

The result and its valid strobe are registered, so they appear one cycle after an accepted input.

Top module: `hsub_unit`

## Requirements
- R1: With `elem_sel` = 0, each adjacent pair of 16-bit elements (bits 2p*16 and (2p+1)*16 within a lane) produces one 16-bit result equal to the lower element minus the upper element.
- R2: With `elem_sel` = 1, each adjacent pair of 32-bit elements produces one 32-bit result equal to the lower element minus the upper element.
- R3: Within each 128-bit lane, results from `src_a` fill the lower 64 bits and results from `src_b` fill the upper 64 bits. In each half, the lowest pair's result takes the lowest position.
- R4: With `form_sel` = 0 (legacy narrow), result bits 255:128 equal `src_a[255:128]` as presented with the valid input.
- R5: With `form_sel` = 1 (zeroing narrow), result bits 255:128 are all zero.
- R6: With `form_sel` = 2 or 3 (wide), the upper lane is computed from `src_a[255:128]` and `src_b[255:128]` by the same rule as lane 0, independently of lane 0.
- R7: Subtraction wraps modulo 2^width. There is no saturation: 0x8000 - 0x0001 gives 0x7FFF, and 0x7FFF - 0xFFFF gives 0x8000.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` carries the result of the accepted input in that same cycle.
- R9: When `in_valid` is low, `out_data` holds its value, and `src_a`, `src_b`, `elem_sel` and `form_sel` have no effect on it.
- R10: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| elem_sel | input | 1 | Element size: 0 = 16-bit, 1 = 32-bit |
| form_sel | input | 2 | 0 = keep upper half, 1 = zero upper half, 2/3 = full width |
| src_a | input | 256 | First source; also the old destination value |
| src_b | input | 256 | Second source |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 256 | Packed difference vector |

## Verification
In a single operation, the pair arithmetic can wrap at its signed limits while the upper-half rule for the chosen form also applies. The bench provokes this by sending extreme element values (the most negative value, the most positive value, and -1) back to back. Between consecutive valid cycles it switches the element size and the form select. A behavioural model builds each expected 256-bit vector element by element and compares it with the registered output on every clock. Idle cycles with scrambled controls are interleaved to show that the held result is not disturbed.

// File: rtl/hsub_pkg.sv
package hsub_pkg;

   localparam int HSUB_VEC_W  = 256;
   localparam int HSUB_LANE_W = 128;

   typedef enum logic [1:0] {
      FORM_KEEP_UPPER = 2'd0,
      FORM_ZERO_UPPER = 2'd1,
      FORM_WIDE       = 2'd2,
      FORM_WIDE_ALT   = 2'd3
   } hsub_form_e;

   function automatic logic form_is_wide(input hsub_form_e f);
      return (f == FORM_WIDE) || (f == FORM_WIDE_ALT);
   endfunction

endpackage

// File: rtl/hsub_pairs.sv
module hsub_pairs #(
   parameter int LANE_W = 128,
   parameter int ELEM_W = 16
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   output logic [LANE_W-1:0] res
);
   localparam int N_ELEM = LANE_W / ELEM_W;
   localparam int N_PAIR = N_ELEM / 2;

   if ((LANE_W % (2 * ELEM_W)) != 0) begin : g_bad_elem
      $error("hsub_pairs: LANE_W must hold a whole number of element pairs");
   end

   // R1 R2 R3: first source fills the low half, second source the high half
   for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      assign res[p*ELEM_W +: ELEM_W] =
         a_lane[(2*p)*ELEM_W +: ELEM_W] - a_lane[(2*p+1)*ELEM_W +: ELEM_W];
      assign res[(N_PAIR+p)*ELEM_W +: ELEM_W] =
         b_lane[(2*p)*ELEM_W +: ELEM_W] - b_lane[(2*p+1)*ELEM_W +: ELEM_W];
   end

endmodule

// File: rtl/hsub_lane.sv
module hsub_lane #(
   parameter int LANE_W   = 128,
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 32
) (
   input  logic [LANE_W-1:0] a_lane,
   input  logic [LANE_W-1:0] b_lane,
   input  logic              wide_elem,
   output logic [LANE_W-1:0] res
);
   logic [LANE_W-1:0] res_narrow;
   logic [LANE_W-1:0] res_wide;

   if (WIDE_W != 2 * NARROW_W) begin : g_bad_sizes
      $error("hsub_lane: WIDE_W must be twice NARROW_W");
   end

   hsub_pairs #(.LANE_W(LANE_W), .ELEM_W(NARROW_W)) u_narrow (
      .a_lane (a_lane),
      .b_lane (b_lane),
      .res    (res_narrow)
   );

   hsub_pairs #(.LANE_W(LANE_W), .ELEM_W(WIDE_W)) u_wide (
      .a_lane (a_lane),
      .b_lane (b_lane),
      .res    (res_wide)
   );

   assign res = wide_elem ? res_wide : res_narrow;

endmodule

// File: rtl/hsub_form_sel.sv
module hsub_form_sel
   import hsub_pkg::*;
#(
   parameter int VEC_W  = 256,
   parameter int LANE_W = 128
) (
   input  hsub_form_e              form,
   input  logic [VEC_W-1:0]        lane_res,
   input  logic [VEC_W-1:LANE_W]   old_upper,
   output logic [VEC_W-1:0]        dst
);
   always_comb begin
      dst[LANE_W-1:0] = lane_res[LANE_W-1:0];
      if (form_is_wide(form)) begin
         dst[VEC_W-1:LANE_W] = lane_res[VEC_W-1:LANE_W];       // R6
      end else if (form == FORM_ZERO_UPPER) begin
         dst[VEC_W-1:LANE_W] = '0;                             // R5
      end else begin
         dst[VEC_W-1:LANE_W] = old_upper;                      // R4
      end
   end

endmodule

// File: rtl/hsub_unit.sv
module hsub_unit
   import hsub_pkg::*;
#(
   parameter int VEC_W    = HSUB_VEC_W,
   parameter int LANE_W   = HSUB_LANE_W,
   parameter int NARROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             elem_sel,
   input  logic [1:0]       form_sel,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_data
);
   localparam int NUM_LANES = VEC_W / LANE_W;
   localparam int WIDE_W    = 2 * NARROW_W;

   if ((VEC_W % LANE_W) != 0 || NUM_LANES < 2) begin : g_bad_vec
      $error("hsub_unit: VEC_W must be at least two whole lanes");
   end
   if ((LANE_W % (4 * WIDE_W)) != 0) begin : g_bad_lane
      $error("hsub_unit: a lane must hold two wide pairs per source");
   end

   logic [VEC_W-1:0] lane_res;
   logic [VEC_W-1:0] next_data;
   hsub_form_e       form_q;

   assign form_q = hsub_form_e'(form_sel);

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      hsub_lane #(.LANE_W(LANE_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_lane (
         .a_lane    (src_a[l*LANE_W +: LANE_W]),
         .b_lane    (src_b[l*LANE_W +: LANE_W]),
         .wide_elem (elem_sel),
         .res       (lane_res[l*LANE_W +: LANE_W])
      );
   end

   hsub_form_sel #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_form (
      .form      (form_q),
      .lane_res  (lane_res),
      .old_upper (src_a[VEC_W-1:LANE_W]),
      .dst       (next_data)
   );

   // R8 R9 R10: one-cycle result register, loaded only on accepted input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= next_data;
         end
      end
   end

   p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   p_zero_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && form_sel == 2'd1) |=> (out_data[VEC_W-1:LANE_W] == '0));

   p_keep_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && form_sel == 2'd0) |=>
         (out_data[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W])));

   p_reset_clear_r10: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && out_data == '0));

endmodule

// File: tb/hsub_unit_tb.sv
`timescale 1ns/1ps
module hsub_unit_tb;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic         elem_sel;
   logic [1:0]   form_sel;
   logic [255:0] src_a;
   logic [255:0] src_b;
   logic         out_valid;
   logic [255:0] out_data;

   int           n_tests = 0;
   int           n_fail  = 0;
   bit           done    = 1'b0;
   logic         exp_valid;
   logic [255:0] exp_data;
   string        cur_tag = "R10";

   always #2 clk = ~clk;

   hsub_unit u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .elem_sel (elem_sel),
      .form_sel (form_sel), .src_a (src_a), .src_b (src_b),
      .out_valid (out_valid), .out_data (out_data)
   );

   // Behavioural model: walk the destination element by element
   function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                          input logic sz, input logic [1:0] fm);
      logic [255:0] r = '0;
      int lanes = (fm >= 2) ? 2 : 1;
      for (int l = 0; l < lanes; l++) begin
         if (!sz) begin
            for (int k = 0; k < 8; k++) begin
               logic [127:0] s = (k < 4) ? a[l*128 +: 128] : b[l*128 +: 128];
               int p = k % 4;
               r[l*128 + k*16 +: 16] = s[p*32 +: 16] - s[p*32+16 +: 16];
            end
         end else begin
            for (int k = 0; k < 4; k++) begin
               logic [127:0] s = (k < 2) ? a[l*128 +: 128] : b[l*128 +: 128];
               int p = k % 2;
               r[l*128 + k*32 +: 32] = s[p*64 +: 32] - s[p*64+32 +: 32];
            end
         end
      end
      if (fm == 2'd0) r[255:128] = a[255:128];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_valid <= 1'b0;
         exp_data  <= '0;
      end else begin
         exp_valid <= in_valid;
         if (in_valid) exp_data <= model(src_a, src_b, elem_sel, form_sel);
      end
   end

   task automatic compare();
      n_tests++;
      if (out_valid !== exp_valid) begin
         n_fail++;
         $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
      end
      n_tests++;
      if (out_data !== exp_data) begin
         n_fail++;
         $display("FAIL %s out_data actual=%h expected=%h", cur_tag, out_data, exp_data);
      end
   endtask

   task automatic op(input logic [255:0] a, input logic [255:0] b,
                     input logic sz, input logic [1:0] fm, input string tag);
      @(negedge clk);
      compare();
      in_valid = 1'b1; src_a = a; src_b = b; elem_sel = sz; form_sel = fm;
      cur_tag = tag;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      compare();
      in_valid = 1'b0;
      src_a = {8{$urandom()}}; src_b = {8{$urandom()}};
      elem_sel = $urandom(); form_sel = $urandom();
      cur_tag = tag;
   endtask

   function automatic logic [255:0] rnd256();
      return {$urandom(), $urandom(), $urandom(), $urandom(),
              $urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [255:0] a, b;
      rst_n = 1'b0; in_valid = 1'b0; elem_sel = 1'b0; form_sel = 2'd0;
      src_a = '0; src_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      n_tests++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         n_fail++;
         $display("FAIL R10 reset actual=%0b/%h expected=0/0", out_valid, out_data);
      end
      rst_n = 1'b1;

      // R1 R3: distinct words, wide form so every lane shows placement
      for (int i = 0; i < 16; i++) begin
         a[i*16 +: 16] = 16'(i * 3 + 7);
         b[i*16 +: 16] = 16'(100 - i * 5);
      end
      op(a, b, 1'b0, 2'd2, "R1_R3_R6");
      // R2 R3
      op(a, b, 1'b1, 2'd2, "R2_R3_R6");
      // R7 wrap corners, 16-bit, with R4 keep on top
      a = '0; b = '0;
      a[15:0] = 16'h8000; a[31:16] = 16'h0001;
      a[47:32] = 16'h7FFF; a[63:48] = 16'hFFFF;
      b[15:0] = 16'h0000; b[31:16] = 16'h8000;
      a[255:128] = {4{32'hDEAD_BEEF}};
      op(a, b, 1'b0, 2'd0, "R7_R4");
      // R7 32-bit wrap, R5 zero upper
      a[31:0] = 32'h8000_0000; a[63:32] = 32'h0000_0001;
      b[31:0] = 32'h7FFF_FFFF; b[63:32] = 32'hFFFF_FFFF;
      op(a, b, 1'b1, 2'd1, "R7_R5");
      // R9: idle cycles with scrambled controls
      idle("R9");
      idle("R9");
      idle("R9");
      // R6 alternate wide code, lane independence
      a = rnd256(); b = rnd256();
      op(a, b, 1'b0, 2'd3, "R6");
      op(a, b, 1'b1, 2'd3, "R6");
      // R8 back-to-back valid with mixed idles, random patterns
      for (int i = 0; i < 200; i++) begin
         if ($urandom_range(0, 3) == 0) idle("R9");
         else op(rnd256(), rnd256(), 1'($urandom()), 2'($urandom()), "R8_mixed");
      end
      idle("R8_mixed");
      idle("R9");
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule